// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block gathers 64 level-sensitive interrupt request lines and presents one winner to the processor. It is a priority level (the winner's 8-bit priority byte) and a vector number. Software reaches the block through a 32-bit register port whose byte offsets span a 256-byte window.

Each source has its own priority byte, a mask bit and a software force bit. A source takes part in arbitration when its line is high or its force bit is set, its priority byte is nonzero, and its mask bit is clear. The arbitration result is registered. The level and vector therefore follow the register and line state seen at the previous clock edge. A software acknowledge register returns the vector the block is currently driving.

Top module: `prio_intc`

## Requirements
- R1: Source n is a candidate only when (line n OR force bit n) is 1, its enable bit is 1, and mask bit n is 0.
- R2: Among candidates, the one with the largest priority byte wins. When priority bytes are equal, the higher source number wins.
- R3: With a winner, `cpu_vector` is the source number plus 64 and `cpu_level` is its priority byte. With no candidate, `cpu_vector` is 24 and `cpu_level` is 0.
- R4: The priority byte of source n is written and read in bits 7:0 at offset 0x40+n. Writing a nonzero byte sets the enable bit of source n, and writing zero clears it.
- R5: Reads of offset 0x00 return lines 63:32 and reads of 0x04 return lines 31:0. Writes to these two offsets change nothing.
- R6: A write to 0x08 replaces mask bits 63:32 and a write to 0x0C replaces mask bits 31:0. In each case the other half keeps its value. Both halves read back at the same offsets.
- R7: A write to 0x1C sets mask bit (data AND 0x3F). A write to 0x1D clears mask bit (data AND 0x3F). No other mask bit changes.
- R8: Force bits 63:32 are written and read at 0x10, and force bits 31:0 at 0x14.
- R9: A read of 0xE0 returns the value now on `cpu_vector`, zero-extended.
- R10: After reset, all priority bytes, enable bits and force bits are 0, all mask bits are 1, `cpu_vector` is 24 and `cpu_level` is 0.
- R11: `cpu_level` and `cpu_vector` change at the first clock edge after the line or register change that causes them.
- R12: Reads of any offset not listed above return 0, and writes to such offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_lines | input | 64 | Level-sensitive request lines, bit n is source n |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| cpu_level | output | 8 | Priority byte of the winning source, 0 when idle |
| cpu_vector | output | 8 | Winning source plus 64, or 24 when idle |

## Verification
A register write takes effect at the edge that samples it, so read data for that offset changes in the same cycle after that edge. The level and vector reflect it one edge later. A line change is seen by the arbiter at the next edge and shows on the outputs right after that edge. The reference model in the bench computes its expected outputs at each rising edge from the state before that edge's write. It then applies the write. It compares outputs and read data at the following falling edge, which matches these latencies exactly.

// File: rtl/intc_pkg.sv
// Package: shared constants of the prioritized interrupt controller.
// Assumes 64 sources split into two 32-bit halves and 8-bit offsets.
package intc_pkg;
    localparam int PRIO_W    = 8;
    localparam int VEC_W     = 8;
    localparam int VEC_BASE  = 64;
    localparam int VEC_NONE  = 24;

    localparam logic [7:0] OFS_LINE_HI  = 8'h00;
    localparam logic [7:0] OFS_LINE_LO  = 8'h04;
    localparam logic [7:0] OFS_MASK_HI  = 8'h08;
    localparam logic [7:0] OFS_MASK_LO  = 8'h0C;
    localparam logic [7:0] OFS_FRC_HI   = 8'h10;
    localparam logic [7:0] OFS_FRC_LO   = 8'h14;
    localparam logic [7:0] OFS_MASK_SET = 8'h1C;
    localparam logic [7:0] OFS_MASK_CLR = 8'h1D;
    localparam logic [7:0] OFS_PRIO     = 8'h40;
    localparam logic [7:0] OFS_ACK      = 8'hE0;
endpackage

// File: rtl/intc_regs.sv
// Module: software-visible state: mask, force, per-source priority and enable.
// Assumes NSRC == 2*DW and that the priority block base is NSRC-aligned.
module intc_regs
    import intc_pkg::*;
#(
    parameter int NSRC = 64,
    parameter int DW   = 32,
    parameter int AW   = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [AW-1:0]                addr,
    input  logic [DW-1:0]                wdata,
    output logic [NSRC-1:0]              mask_q,
    output logic [NSRC-1:0]              force_q,
    output logic [NSRC-1:0]              en_q,
    output logic [NSRC-1:0][PRIO_W-1:0]  prio_q
);
    localparam int IDX_W = $clog2(NSRC);

    // Mask and force registers, written as halves or single mask bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q  <= '1;
            force_q <= '0;
        end else if (wr_en) begin
            if (addr == OFS_MASK_HI)  mask_q[NSRC-1:DW]  <= wdata;
            if (addr == OFS_MASK_LO)  mask_q[DW-1:0]     <= wdata;
            if (addr == OFS_FRC_HI)   force_q[NSRC-1:DW] <= wdata;
            if (addr == OFS_FRC_LO)   force_q[DW-1:0]    <= wdata;
            if (addr == OFS_MASK_SET) mask_q[wdata[IDX_W-1:0]] <= 1'b1;
            if (addr == OFS_MASK_CLR) mask_q[wdata[IDX_W-1:0]] <= 1'b0;
        end
    end

    // One priority byte and enable bit per source.
    for (genvar g = 0; g < NSRC; g++) begin : g_src
        logic hit;
        assign hit = wr_en && (addr == AW'(int'(OFS_PRIO) + g));

        // Store the priority byte; enable follows whether it is nonzero.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prio_q[g] <= '0;
                en_q[g]   <= 1'b0;
            end else if (hit) begin
                prio_q[g] <= wdata[PRIO_W-1:0];
                en_q[g]   <= |wdata[PRIO_W-1:0];
            end
        end
    end
endmodule

// File: rtl/intc_arbiter.sv
// Module: registered priority search over all candidate sources.
// Assumes enabled sources have nonzero priority; ties favour higher index.
module intc_arbiter
    import intc_pkg::*;
#(
    parameter int NSRC = 64
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NSRC-1:0]              line_i,
    input  logic [NSRC-1:0]              force_i,
    input  logic [NSRC-1:0]              en_i,
    input  logic [NSRC-1:0]              mask_i,
    input  logic [NSRC-1:0][PRIO_W-1:0]  prio_i,
    output logic [PRIO_W-1:0]            level_q,
    output logic [VEC_W-1:0]             vector_q
);
    localparam int IDX_W = $clog2(NSRC);

    logic [NSRC-1:0]   cand;
    logic [PRIO_W-1:0] best_prio;
    logic [IDX_W-1:0]  best_idx;
    logic              found;

    // Linear scan with >= so the last equal-priority candidate is kept.
    always_comb begin
        cand      = (line_i | force_i) & en_i & ~mask_i;
        best_prio = '0;
        best_idx  = '0;
        found     = 1'b0;
        for (int i = 0; i < NSRC; i++) begin
            if (cand[i] && prio_i[i] >= best_prio) begin
                best_prio = prio_i[i];
                best_idx  = IDX_W'(i);
                found     = 1'b1;
            end
        end
    end

    // Register the winner's level and vector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q  <= '0;
            vector_q <= VEC_W'(VEC_NONE);
        end else begin
            level_q  <= found ? best_prio : '0;
            vector_q <= found ? VEC_W'(VEC_BASE + int'(best_idx)) : VEC_W'(VEC_NONE);
        end
    end
endmodule

// File: rtl/prio_intc.sv
// Module: top of the prioritized interrupt controller with read multiplexer.
// Assumes single-cycle write strobes and a combinational read port.
module prio_intc
    import intc_pkg::*;
#(
    parameter int NSRC = 64,
    parameter int DW   = 32,
    parameter int AW   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   irq_lines,
    input  logic              reg_wr,
    input  logic [AW-1:0]     reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    output logic [PRIO_W-1:0] cpu_level,
    output logic [VEC_W-1:0]  cpu_vector
);
    localparam int IDX_W = $clog2(NSRC);

    logic [NSRC-1:0]             mask_q;
    logic [NSRC-1:0]             force_q;
    logic [NSRC-1:0]             en_q;
    logic [NSRC-1:0][PRIO_W-1:0] prio_q;

    intc_regs #(.NSRC(NSRC), .DW(DW), .AW(AW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .mask_q  (mask_q),
        .force_q (force_q),
        .en_q    (en_q),
        .prio_q  (prio_q)
    );

    intc_arbiter #(.NSRC(NSRC)) u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_i   (irq_lines),
        .force_i  (force_q),
        .en_i     (en_q),
        .mask_i   (mask_q),
        .prio_i   (prio_q),
        .level_q  (cpu_level),
        .vector_q (cpu_vector)
    );

    // Decode the read offset into the selected register value.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr >= OFS_PRIO && reg_addr < AW'(int'(OFS_PRIO) + NSRC)) begin
            reg_rdata = DW'(prio_q[reg_addr[IDX_W-1:0]]);
        end else begin
            case (reg_addr)
                OFS_LINE_HI: reg_rdata = irq_lines[NSRC-1:DW];
                OFS_LINE_LO: reg_rdata = irq_lines[DW-1:0];
                OFS_MASK_HI: reg_rdata = mask_q[NSRC-1:DW];
                OFS_MASK_LO: reg_rdata = mask_q[DW-1:0];
                OFS_FRC_HI:  reg_rdata = force_q[NSRC-1:DW];
                OFS_FRC_LO:  reg_rdata = force_q[DW-1:0];
                OFS_ACK:     reg_rdata = DW'(cpu_vector);
                default:     reg_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/intc_checker.sv
// Module: temporal checks on the controller, attached by bind.
// Assumes default 64 sources; observes top-level state signals.
module intc_checker
    import intc_pkg::*;
#(
    parameter int NSRC = 64
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         reg_wr,
    input logic [7:0]                   reg_addr,
    input logic [5:0]                   wlow,
    input logic [NSRC-1:0]              irq_lines,
    input logic [PRIO_W-1:0]            cpu_level,
    input logic [VEC_W-1:0]             cpu_vector,
    input logic [NSRC-1:0]              mask_q,
    input logic [NSRC-1:0]              force_q,
    input logic [NSRC-1:0]              en_q,
    input logic [NSRC-1:0][PRIO_W-1:0]  prio_q
);
    logic [NSRC-1:0]             cand_d;
    logic [NSRC-1:0][PRIO_W-1:0] prio_d;
    logic [NSRC-1:0]             nz;

    // Delay candidate set and priorities to line up with registered outputs.
    always_ff @(posedge clk) begin
        cand_d <= (irq_lines | force_q) & en_q & ~mask_q;
        prio_d <= prio_q;
    end

    // Nonzero flag of each priority byte.
    always_comb begin
        for (int i = 0; i < NSRC; i++) nz[i] = |prio_q[i];
    end

    AST_IDLE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_vector == 8'd24) == (cpu_level == 8'd0)); // R3
    AST_VECTOR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_vector == 8'd24 || cpu_vector[7:6] == 2'b01); // R3
    AST_WINNER_CANDIDATE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && cpu_vector != 8'd24) |-> cand_d[cpu_vector[5:0]]); // R1
    AST_WINNER_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && cpu_vector != 8'd24) |-> cpu_level == prio_d[cpu_vector[5:0]]); // R2
    AST_ENABLE_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        en_q == nz); // R4
    AST_MASK_HALF_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && reg_wr && reg_addr == OFS_MASK_HI) |-> $stable(mask_q[31:0])); // R6
    AST_MASK_SET_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && reg_wr && reg_addr == OFS_MASK_SET) |-> mask_q[$past(wlow)]); // R7
    AST_MASK_CLR_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && reg_wr && reg_addr == OFS_MASK_CLR) |-> !mask_q[$past(wlow)]); // R7
endmodule

bind prio_intc intc_checker #(.NSRC(NSRC)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .wlow       (reg_wdata[5:0]),
    .irq_lines  (irq_lines),
    .cpu_level  (cpu_level),
    .cpu_vector (cpu_vector),
    .mask_q     (mask_q),
    .force_q    (force_q),
    .en_q       (en_q),
    .prio_q     (prio_q)
);

// File: tb/sim_prio_intc.sv
module sim_prio_intc;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] irq_lines = '0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [7:0]  cpu_level;
    logic [7:0]  cpu_vector;

    int n_checks = 0;
    int n_fails  = 0;
    bit started  = 0;
    bit done     = 0;

    // Reference model state
    int          m_prio [64];
    logic [63:0] m_mask;
    logic [63:0] m_force;
    int          e_lvl;
    int          e_vec;

    always #(CLK_PERIOD/2) clk = ~clk;

    prio_intc u0 (
        .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .cpu_level(cpu_level), .cpu_vector(cpu_vector)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Model: outputs from state before the edge, then apply the write.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 64; i++) m_prio[i] = 0;
            m_mask = '1; m_force = '0; e_lvl = 0; e_vec = 24;
        end else begin
            int bl, bi;
            bl = 0; bi = -1;
            for (int i = 63; i >= 0; i--) begin
                if ((irq_lines[i] || m_force[i]) && m_prio[i] != 0 && !m_mask[i] && m_prio[i] > bl) begin
                    bl = m_prio[i]; bi = i;
                end
            end
            e_lvl = bl;
            e_vec = (bi < 0) ? 24 : bi + 64;
            if (reg_wr) begin
                if (reg_addr >= 8'h40 && reg_addr < 8'h80) m_prio[reg_addr - 8'h40] = reg_wdata[7:0];
                else if (reg_addr == 8'h08) m_mask[63:32] = reg_wdata;
                else if (reg_addr == 8'h0C) m_mask[31:0]  = reg_wdata;
                else if (reg_addr == 8'h10) m_force[63:32] = reg_wdata;
                else if (reg_addr == 8'h14) m_force[31:0]  = reg_wdata;
                else if (reg_addr == 8'h1C) m_mask[reg_wdata & 32'h3F] = 1'b1;
                else if (reg_addr == 8'h1D) m_mask[reg_wdata & 32'h3F] = 1'b0;
            end
            started = 1;
        end
    end

    function automatic longint exp_read(input logic [7:0] a);
        if (a >= 8'h40 && a < 8'h80) return m_prio[a - 8'h40];
        case (a)
            8'h00: return irq_lines[63:32];
            8'h04: return irq_lines[31:0];
            8'h08: return m_mask[63:32];
            8'h0C: return m_mask[31:0];
            8'h10: return m_force[63:32];
            8'h14: return m_force[31:0];
            8'hE0: return e_vec;
            default: return 0;
        endcase
    endfunction

    function automatic string read_tag(input logic [7:0] a);
        if (a >= 8'h40 && a < 8'h80) return "R4";
        case (a)
            8'h00, 8'h04: return "R5";
            8'h08, 8'h0C: return "R6";
            8'h10, 8'h14: return "R8";
            8'hE0: return "R9";
            default: return "R12";
        endcase
    endfunction

    // Compare on every clock, away from the active edge.
    always @(negedge clk) begin
        #1;
        if (started && rst_n && !done) begin
            check(cpu_level == e_lvl, "R1 R2 R3 R11 level", cpu_level, e_lvl);
            check(cpu_vector == e_vec, "R1 R2 R3 R11 vector", cpu_vector, e_vec);
            check(reg_rdata == exp_read(reg_addr), read_tag(reg_addr), reg_rdata, exp_read(reg_addr));
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 0; reg_addr = 8'hFF;
    endtask

    task automatic rd_chk(input logic [7:0] a, input longint exp, input string tag);
        @(negedge clk); reg_addr = a; #2;
        check(reg_rdata == exp, tag, reg_rdata, exp);
    endtask

    task automatic out_chk(input int vec, input int lvl, input string tag);
        @(negedge clk); @(negedge clk); #2;
        check(cpu_vector == vec && cpu_level == lvl, tag, {cpu_level, cpu_vector}, {lvl[7:0], vec[7:0]});
    endtask

    task automatic lines(input logic [63:0] v);
        @(negedge clk); irq_lines = v;
    endtask

    // Watchdog
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            check(0, "watchdog", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] lfsr;
        repeat (3) @(negedge clk);
        rst_n = 1;
        #2;
        check(cpu_vector == 24 && cpu_level == 0, "R10 outputs", {cpu_level, cpu_vector}, 24);
        rd_chk(8'h08, 32'hFFFF_FFFF, "R10 mask hi");
        rd_chk(8'h0C, 32'hFFFF_FFFF, "R10 mask lo");
        rd_chk(8'h40, 0, "R10 prio");
        rd_chk(8'h14, 0, "R10 force");
        rd_chk(8'hE0, 24, "R10 ack");

        wr(8'h45, 3); wr(8'h4A, 3); wr(8'h68, 7);
        rd_chk(8'h68, 7, "R4 readback");
        wr(8'h0C, 0); wr(8'h08, 0);
        lines(64'h1 << 5);          out_chk(69, 3, "R3 single source");
        lines(64'h1 << 5 | 64'h1 << 10); out_chk(74, 3, "R2 tie to higher");
        lines(64'h1 << 5 | 64'h1 << 10 | 64'h1 << 40); out_chk(104, 7, "R2 higher priority");
        rd_chk(8'hE0, 104, "R9 ack");
        wr(8'h1C, 40);              out_chk(74, 3, "R7 set mask");
        wr(8'h1D, 32'hE8);          out_chk(104, 7, "R7 clear mask with 6-bit index");
        wr(8'h68, 0);               out_chk(74, 3, "R4 zero disables");
        wr(8'h72, 2); wr(8'h10, 32'h1 << 18);
        lines(64'h0);               out_chk(114, 2, "R8 forced source");
        wr(8'h00, 32'hFFFF_FFFF); wr(8'h04, 32'hFFFF_FFFF);
        rd_chk(8'h04, 0, "R5 line write ignored");
        wr(8'h20, 32'h1234); rd_chk(8'h20, 0, "R12 undefined read");
        rd_chk(8'h0C, 0, "R12 undefined write ignored");
        wr(8'h08, 32'hFFFF_FFFF);   out_chk(24, 0, "R6 upper half masked");
        rd_chk(8'h0C, 0, "R6 lower half kept");
        wr(8'h40, 1); wr(8'h14, 1); out_chk(64, 1, "R1 forced low source");
        lines(64'h0);               out_chk(64, 1, "R11 stable");
        wr(8'h14, 0);               out_chk(24, 0, "R3 idle");

        lfsr = 32'hACE1_1234;
        for (int k = 0; k < 600; k++) begin
            @(negedge clk);
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            irq_lines = {lfsr, lfsr ^ 32'h5A5A_0F0F} & {lfsr[15:0], lfsr, lfsr[31:16]};
            reg_wr = lfsr[3];
            case (lfsr[7:4])
                4'd0: reg_addr = 8'h0C;
                4'd1: reg_addr = 8'h08;
                4'd2: reg_addr = 8'h10;
                4'd3: reg_addr = 8'h14;
                4'd4: reg_addr = 8'h1C;
                4'd5, 4'd6: reg_addr = 8'h1D;
                4'd7: reg_addr = 8'h00;
                4'd8: reg_addr = 8'hE0;
                4'd9: reg_addr = 8'h33;
                default: reg_addr = 8'h40 + {2'b00, lfsr[13:8]};
            endcase
            reg_wdata = (reg_addr == 8'h0C || reg_addr == 8'h08) ? (lfsr & {lfsr[7:0], lfsr[31:8]}) : lfsr;
            if (reg_addr >= 8'h40 && reg_addr < 8'h80) reg_wdata = {24'h0, 1'b0, lfsr[18:17], lfsr[20] ? 5'd0 : 5'd1};
        end
        @(negedge clk); reg_wr = 0;
        repeat (3) @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule